// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 64-byte type-0 configuration header of a single device function. A host-side agent hands it one request per cycle: a byte offset into the header, an access width in bytes and, for writes, a data word. One cycle later the block returns the addressed bytes, or pulses an error flag when the access is not allowed. At reset the whole header is cleared and then loaded from parameters: identification fields, class codes, the six base address registers, the expansion ROM register and the interrupt fields.

Writes are filtered by width and by target. Only a few fields take narrow writes. The base address registers take full-word writes and answer an all-ones write with a size mask, while their low type bits stay read-only. The expansion ROM register has its own sizing code. Any access that is not allowed leaves the header untouched.

Top module: `cfg_hdr_regs`

## Requirements
- R1: After reset the header reads back little-endian, as follows. Vendor id is at 0x00 and device id at 0x02, each 16 bits. Command is at 0x04 and status at 0x06, each 16 bits. The bytes at 0x08 to 0x0F hold, in order: revision, programming interface, subclass, base class, cache line size, latency timer, header type and self-test. BAR i is a 32-bit word at 0x10+4*i for i = 0..5. The card information pointer is a 32-bit word at 0x28. Subsystem vendor id is at 0x2C and subsystem id at 0x2E, each 16 bits. The ROM base is a 32-bit word at 0x30. The bytes at 0x3C to 0x3F hold, in order: interrupt line, interrupt pin, minimum grant and maximum latency. Every other byte is zero. During reset and in the first cycle after it, err and rd_valid are 0.
- R2: A read of size 1, 2 or 4 at offset o with o+size <= 64 makes rd_valid 1 and err 0 in the next cycle. rd_data then holds byte o in bits 7:0, byte o+1 in bits 15:8 and so on, with the unused upper bytes at zero.
- R3: A read of any other size (0, 3, 5, 6 or 7), or one with o+size > 64, makes err 1 and rd_valid 0 in the next cycle.
- R4: A 1-byte write is accepted only at 0x0C (cache line size) and 0x3C (interrupt line), and takes req_wdata[7:0]. A 1-byte write at any other offset is flagged.
- R5: A 2-byte write is accepted only at 0x04, 0x06 and 0x0C, and stores req_wdata[15:0] into bytes o and o+1. A 2-byte write at any other offset is flagged. Writes of size 0, 3, 5, 6 or 7 are always flagged.
- R6: A BAR whose stored bit 0 is 1 is an I/O BAR, and its bits 1:0 are read-only. Any other BAR is a memory BAR, and its bits 3:0 are read-only. A 4-byte write of a value other than all ones stores the written bits above the read-only field.
- R7: A 4-byte write of 0xFFFFFFFF to BAR i stores ~(2^BAR_SZ_LOG2[i] - 1), with the read-only type bits kept from the old value.
- R8: A 4-byte write of 0xFFFFFFFE to 0x30 stores 0xFFFFFFFF. Any other 4-byte value written to 0x30 is stored unchanged.
- R9: A 4-byte write at 0x04 updates only the command bytes 0x04 and 0x05 from req_wdata[15:0], and the status is kept. A 4-byte write at any offset other than a BAR, 0x30 or 0x04 is flagged.
- R10: A flagged access raises err for exactly the following cycle, keeps rd_valid at 0 and leaves every header byte unchanged.
- R11: A write commits at the clock edge that accepts it, so a read issued in the very next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, reloads the header |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 6 | Byte offset into the header |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data, little-endian, low bytes used for narrow writes |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's read |
| rd_data | output | 32 | Read result, zero-extended |
| err | output | 1 | One-cycle flag for the previous cycle's illegal request |

## Verification
Two functions can meet in the same cycle. A write commits to the header at one edge, and at the next edge a read of that same location captures its data. The bench provokes this by issuing requests on every cycle with no idle gap, including a BAR sizing write followed at once by a read-back and a command write followed by a status read. A behavioural byte-array model, updated in request order, judges every returned word, error pulse and valid flag on each clock.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

   // fixed layout of a type-0 header
   localparam int HDR_BYTES = 64;
   localparam int HDR_BITS  = HDR_BYTES * 8;
   localparam int OFS_W     = $clog2(HDR_BYTES);
   localparam int NUM_BARS  = 6;
   localparam int BIDX_W    = $clog2(NUM_BARS);
   localparam int LOG2_W    = 5;

   localparam logic [OFS_W-1:0] OFS_CMD   = OFS_W'(8'h04);
   localparam logic [OFS_W-1:0] OFS_STAT  = OFS_W'(8'h06);
   localparam logic [OFS_W-1:0] OFS_CLS   = OFS_W'(8'h0C);
   localparam logic [OFS_W-1:0] OFS_BAR0  = OFS_W'(8'h10);
   localparam logic [OFS_W-1:0] OFS_ROM   = OFS_W'(8'h30);
   localparam logic [OFS_W-1:0] OFS_ILINE = OFS_W'(8'h3C);

   typedef enum logic [2:0] {
      WK_NONE,
      WK_BYTE,
      WK_HALF,
      WK_CMD,
      WK_BAR,
      WK_ROM
   } wr_kind_e;

endpackage

// File: rtl/cfg_access_check.sv
module cfg_access_check
   import cfg_hdr_pkg::*;
(
   input  logic              wr,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [2:0]        size,
   output logic              legal,
   output wr_kind_e          kind,
   output logic [BIDX_W-1:0] bar_idx
);

   logic in_range;
   logic bar_hit;

   assign in_range = (int'(ofs) + int'(size)) <= HDR_BYTES;
   assign bar_hit  = (ofs >= OFS_BAR0) &&
                     (int'(ofs) < int'(OFS_BAR0) + 4 * NUM_BARS) &&
                     (ofs[1:0] == 2'b00);

   always_comb begin
      legal   = 1'b0;
      kind    = WK_NONE;
      bar_idx = BIDX_W'((ofs - OFS_BAR0) >> 2);
      if (!wr) begin
         legal = in_range && (size == 3'd1 || size == 3'd2 || size == 3'd4);
      end else begin
         unique case (size)
            3'd1: if (ofs == OFS_CLS || ofs == OFS_ILINE) kind = WK_BYTE;
            3'd2: if (ofs == OFS_CMD || ofs == OFS_STAT || ofs == OFS_CLS) kind = WK_HALF;
            3'd4: begin
               if (ofs == OFS_CMD)      kind = WK_CMD;
               else if (ofs == OFS_ROM) kind = WK_ROM;
               else if (bar_hit)        kind = WK_BAR;
            end
            default: kind = WK_NONE;
         endcase
         legal = (kind != WK_NONE);
      end
   end

endmodule

// File: rtl/cfg_bar_update.sv
module cfg_bar_update
   import cfg_hdr_pkg::*;
#(
   parameter logic [NUM_BARS*LOG2_W-1:0] SZ_LOG2 = '0
)(
   input  logic [31:0]       old_val,
   input  logic [31:0]       wdata,
   input  logic [BIDX_W-1:0] idx,
   output logic [31:0]       new_val
);

   logic [31:0] size_mask [NUM_BARS];

   // one sizing mask per BAR, fixed at elaboration
   for (genvar i = 0; i < NUM_BARS; i++) begin : g_mask
      assign size_mask[i] = 32'hFFFF_FFFF << SZ_LOG2[i*LOG2_W +: LOG2_W];
   end

   logic [31:0] keep;
   logic [31:0] src;

   always_comb begin
      keep = old_val[0] ? 32'h0000_0003 : 32'h0000_000F;
      if (wdata == 32'hFFFF_FFFF)
         src = (int'(idx) < NUM_BARS) ? size_mask[idx] : 32'hFFFF_FFFF;
      else
         src = wdata;
      new_val = (src & ~keep) | (old_val & keep);
   end

endmodule

// File: rtl/cfg_hdr_store.sv
module cfg_hdr_store
   import cfg_hdr_pkg::*;
#(
   parameter logic [HDR_BITS-1:0] INIT = '0
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [OFS_W-1:0]    wofs,
   input  logic [31:0]         wdata,
   input  logic [3:0]          wbe,
   output logic [HDR_BITS-1:0] img
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         img <= INIT;
      end else if (we) begin
         for (int b = 0; b < 4; b++) begin
            if (wbe[b] && (int'(wofs) + b) < HDR_BYTES)
               img[(int'(wofs) + b) * 8 +: 8] <= wdata[b*8 +: 8];
         end
      end
   end

   // R10
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(img));

endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
   import cfg_hdr_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID  = 16'h1ABC,
   parameter logic [15:0] DEVICE_ID  = 16'h0101,
   parameter logic [15:0] CMD_INIT   = 16'h0000,
   parameter logic [15:0] STAT_INIT  = 16'h0000,
   parameter logic [7:0]  REV_ID     = 8'h00,
   parameter logic [7:0]  PROG_IF    = 8'h00,
   parameter logic [7:0]  SUB_CLASS  = 8'h00,
   parameter logic [7:0]  BASE_CLASS = 8'h02,
   parameter logic [7:0]  CLS_INIT   = 8'h00,
   parameter logic [7:0]  LAT_TIMER  = 8'h00,
   parameter logic [7:0]  HDR_TYPE   = 8'h00,
   parameter logic [7:0]  SELF_TEST  = 8'h00,
   parameter logic [NUM_BARS*32-1:0]     BAR_INIT    = '0,
   parameter logic [NUM_BARS*LOG2_W-1:0] BAR_SZ_LOG2 = {NUM_BARS{5'd4}},
   parameter logic [31:0] CIS_PTR    = 32'h0,
   parameter logic [15:0] SUBSYS_VEN = 16'h0,
   parameter logic [15:0] SUBSYS_ID  = 16'h0,
   parameter logic [31:0] ROM_INIT   = 32'h0,
   parameter logic [7:0]  INT_LINE   = 8'h00,
   parameter logic [7:0]  INT_PIN    = 8'h01,
   parameter logic [7:0]  MIN_GNT    = 8'h00,
   parameter logic [7:0]  MAX_LAT    = 8'h00
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [5:0]  req_offset,
   input  logic [2:0]  req_size,
   input  logic [31:0] req_wdata,
   output logic        rd_valid,
   output logic [31:0] rd_data,
   output logic        err
);

   function automatic logic [HDR_BITS-1:0] build_img();
      logic [HDR_BITS-1:0] v;
      v = '0;
      v[8*8'h00 +: 16] = VENDOR_ID;
      v[8*8'h02 +: 16] = DEVICE_ID;
      v[8*8'h04 +: 16] = CMD_INIT;
      v[8*8'h06 +: 16] = STAT_INIT;
      v[8*8'h08 +: 64] = {SELF_TEST, HDR_TYPE, LAT_TIMER, CLS_INIT,
                          BASE_CLASS, SUB_CLASS, PROG_IF, REV_ID};
      for (int i = 0; i < NUM_BARS; i++)
         v[8*(16 + 4*i) +: 32] = BAR_INIT[i*32 +: 32];
      v[8*8'h28 +: 32] = CIS_PTR;
      v[8*8'h2C +: 16] = SUBSYS_VEN;
      v[8*8'h2E +: 16] = SUBSYS_ID;
      v[8*8'h30 +: 32] = ROM_INIT;
      v[8*8'h3C +: 32] = {MAX_LAT, MIN_GNT, INT_PIN, INT_LINE};
      return v;
   endfunction

   localparam logic [HDR_BITS-1:0] INIT_IMG = build_img();

   // elaboration checks: sizing mask must clear the read-only type field
   for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar_chk
      localparam int L    = int'(BAR_SZ_LOG2[i*LOG2_W +: LOG2_W]);
      localparam int TYPW = BAR_INIT[i*32] ? 2 : 4;
      if (L < TYPW) begin : g_bad
         $error("BAR size below its type field width");
      end
   end

   logic                legal;
   wr_kind_e            kind;
   logic [BIDX_W-1:0]   bar_idx;
   logic [HDR_BITS-1:0] img;
   logic [31:0]         win;
   logic [31:0]         bar_new;
   logic [31:0]         wd;
   logic [3:0]          be;
   logic [31:0]         rmask;
   logic                we;

   cfg_access_check u_chk (
      .wr      (req_write),
      .ofs     (req_offset),
      .size    (req_size),
      .legal   (legal),
      .kind    (kind),
      .bar_idx (bar_idx)
   );

   // 4-byte window starting at the requested offset
   always_comb begin
      win = '0;
      for (int b = 0; b < 4; b++) begin
         if ((int'(req_offset) + b) < HDR_BYTES)
            win[b*8 +: 8] = img[(int'(req_offset) + b) * 8 +: 8];
      end
   end

   cfg_bar_update #(.SZ_LOG2(BAR_SZ_LOG2)) u_bar (
      .old_val (win),
      .wdata   (req_wdata),
      .idx     (bar_idx),
      .new_val (bar_new)
   );

   always_comb begin
      wd = req_wdata;
      be = 4'b0000;
      unique case (kind)
         WK_BYTE: be = 4'b0001;
         WK_HALF,
         WK_CMD:  be = 4'b0011;
         WK_BAR:  begin be = 4'b1111; wd = bar_new; end
         WK_ROM:  begin
            be = 4'b1111;
            if (req_wdata == 32'hFFFF_FFFE) wd = 32'hFFFF_FFFF;
         end
         default: be = 4'b0000;
      endcase
   end

   assign we = req_valid && req_write && legal;

   cfg_hdr_store #(.INIT(INIT_IMG)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .wofs  (req_offset),
      .wdata (wd),
      .wbe   (be),
      .img   (img)
   );

   always_comb begin
      unique case (req_size)
         3'd1:    rmask = 32'h0000_00FF;
         3'd2:    rmask = 32'h0000_FFFF;
         default: rmask = 32'hFFFF_FFFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         err      <= 1'b0;
      end else begin
         err      <= req_valid && !legal;
         rd_valid <= req_valid && !req_write && legal;
         if (req_valid && !req_write && legal)
            rd_data <= win & rmask;
      end
   end

   // R10
   err_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(req_valid) && !rd_valid);

   // R3
   bad_rd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && !(req_size inside {3'd1, 3'd2, 3'd4})
      |=> err && !rd_valid);

   // R2
   dword_rd_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && req_size == 3'd4 && req_offset[1:0] == 2'b00
      |=> rd_valid && !err);

   // R8
   rom_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && req_size == 3'd4 && req_offset == 6'h30 &&
      req_wdata == 32'hFFFF_FFFE
      |=> img[8*8'h30 +: 32] == 32'hFFFF_FFFF);

   // R9
   cmd_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && req_size == 3'd4 && req_offset == 6'h04
      |=> $stable(img[8*8'h06 +: 16]));

   // R6
   for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar_type
      bar_type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> $stable(img[8*(16 + 4*i) +: 2]) &&
                  (img[8*(16 + 4*i)] || $stable(img[8*(16 + 4*i) + 2 +: 2])));
   end

endmodule

// File: tb/cfg_hdr_regs_tb.sv
module cfg_hdr_regs_tb_top;

   localparam int CLK_PERIOD = 10;

   localparam logic [6*32-1:0] T_BAR_INIT = {32'h0000_0000, 32'h0000_0001,
                                             32'h0000_0004, 32'h0000_0000,
                                             32'h0000_C001, 32'h0000_0008};
   localparam logic [6*5-1:0]  T_SZ = {5'd4, 5'd8, 5'd16, 5'd20, 5'd5, 5'd12};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [5:0]  req_offset = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        err;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [31:0] last_rd;

   logic [7:0] ref_img [64];
   int bar_l [6] = '{12, 5, 20, 16, 8, 4};

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_hdr_regs #(
      .VENDOR_ID(16'h1D5A), .DEVICE_ID(16'h7E21), .CMD_INIT(16'h0006),
      .STAT_INIT(16'h0210), .REV_ID(8'h03), .PROG_IF(8'h01),
      .SUB_CLASS(8'h06), .BASE_CLASS(8'h01), .CLS_INIT(8'h10),
      .LAT_TIMER(8'h20), .HDR_TYPE(8'h80), .SELF_TEST(8'h00),
      .BAR_INIT(T_BAR_INIT), .BAR_SZ_LOG2(T_SZ), .CIS_PTR(32'h0000_1234),
      .SUBSYS_VEN(16'hBEEF), .SUBSYS_ID(16'hCAFE), .ROM_INIT(32'h0000_0000),
      .INT_LINE(8'h0B), .INT_PIN(8'h01), .MIN_GNT(8'h05), .MAX_LAT(8'h0A)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .err(err)
   );

   task automatic put(int o, int n, logic [31:0] v);
      for (int b = 0; b < n; b++) ref_img[o+b] = v[b*8 +: 8];
   endtask

   function automatic logic [31:0] get32(int o);
      logic [31:0] v = '0;
      for (int b = 0; b < 4; b++) v[b*8 +: 8] = ref_img[o+b];
      return v;
   endfunction

   task automatic model_init();
      for (int i = 0; i < 64; i++) ref_img[i] = 8'h00;
      put(0, 2, 32'h1D5A);  put(2, 2, 32'h7E21);
      put(4, 2, 32'h0006);  put(6, 2, 32'h0210);
      ref_img[8] = 8'h03;  ref_img[9] = 8'h01;  ref_img[10] = 8'h06;
      ref_img[11] = 8'h01; ref_img[12] = 8'h10; ref_img[13] = 8'h20;
      ref_img[14] = 8'h80; ref_img[15] = 8'h00;
      for (int i = 0; i < 6; i++) put(16 + 4*i, 4, T_BAR_INIT[i*32 +: 32]);
      put(40, 4, 32'h1234); put(44, 2, 32'hBEEF); put(46, 2, 32'hCAFE);
      ref_img[60] = 8'h0B; ref_img[61] = 8'h01;
      ref_img[62] = 8'h05; ref_img[63] = 8'h0A;
   endtask

   task automatic model(input bit wr, input int o, input int sz,
                        input logic [31:0] wd,
                        output bit e_err, output bit e_rdv,
                        output logic [31:0] e_rd);
      e_err = 0; e_rdv = 0; e_rd = '0;
      if (!wr) begin
         if ((sz == 1 || sz == 2 || sz == 4) && o + sz <= 64) begin
            e_rdv = 1;
            for (int b = 0; b < sz; b++) e_rd[b*8 +: 8] = ref_img[o+b];
         end else e_err = 1;
      end else if (sz == 1 && (o == 12 || o == 60)) begin
         put(o, 1, wd);
      end else if (sz == 2 && (o == 4 || o == 6 || o == 12)) begin
         put(o, 2, wd);
      end else if (sz == 4 && o == 4) begin
         put(4, 2, wd);
      end else if (sz == 4 && o == 48) begin
         put(48, 4, (wd == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : wd);
      end else if (sz == 4 && o >= 16 && o <= 36 && o % 4 == 0) begin
         logic [31:0] old, keep, nv;
         logic [63:0] span;
         old  = get32(o);
         keep = old[0] ? 32'h3 : 32'hF;
         if (wd == 32'hFFFF_FFFF) begin
            span = 64'd1 << bar_l[(o - 16) / 4];
            nv = ~(span[31:0] - 32'd1) | (old & keep);
         end else nv = (wd & ~keep) | (old & keep);
         put(o, 4, nv);
      end else e_err = 1;
   endtask

   task automatic chk(bit ok, string tag, string what,
                      logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic req(bit wr, int o, int sz, logic [31:0] wd, string tag);
      bit e_err, e_rdv;
      logic [31:0] e_rd;
      req_valid = 1; req_write = wr; req_offset = o[5:0];
      req_size = sz[2:0]; req_wdata = wd;
      model(wr, o, sz, wd, e_err, e_rdv, e_rd);
      @(negedge clk);
      req_valid = 0;
      chk(err == e_err, tag, "err", 32'(err), 32'(e_err));
      chk(rd_valid == e_rdv, tag, "rd_valid", 32'(rd_valid), 32'(e_rdv));
      if (e_rdv) chk(rd_data == e_rd, tag, "rd_data", rd_data, e_rd);
      last_rd = rd_data;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      finish_run();
   end

   initial begin
      model_init();
      repeat (3) @(negedge clk);
      chk(err == 0 && rd_valid == 0, "R1", "reset outputs", {err, rd_valid}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(err == 0 && rd_valid == 0, "R1", "post-reset outputs", {err, rd_valid}, 0);

      // R1: whole image, dword reads
      for (int o = 0; o < 64; o += 4) req(0, o, 4, 0, "R1");
      req(0, 0, 4, 0, "R1");
      chk(last_rd == 32'h7E21_1D5A, "R1", "id word", last_rd, 32'h7E21_1D5A);

      // R2: narrow and unaligned reads
      req(0, 11, 1, 0, "R2");
      chk(last_rd == 32'h01, "R2", "class byte", last_rd, 32'h01);
      req(0, 13, 2, 0, "R2");
      chk(last_rd == 32'h8020, "R2", "odd half", last_rd, 32'h8020);
      req(0, 41, 4, 0, "R2");
      req(0, 60, 4, 0, "R2");
      req(0, 63, 1, 0, "R2");

      // R3: illegal read sizes and overrun
      req(0, 0, 3, 0, "R3");
      req(0, 8, 0, 0, "R3");
      req(0, 8, 7, 0, "R3");
      req(0, 62, 4, 0, "R3");
      req(0, 63, 2, 0, "R3");

      // R4: byte writes
      req(1, 12, 1, 32'hAAAA_AA40, "R4");
      req(0, 12, 1, 0, "R4");
      chk(last_rd == 32'h40, "R4", "cls byte", last_rd, 32'h40);
      req(1, 60, 1, 32'h0000_0077, "R4");
      req(1, 61, 1, 32'h0000_0033, "R4");
      req(1, 0, 1, 32'h0000_0033, "R4");
      req(0, 60, 2, 0, "R10");
      chk(last_rd == 32'h0177, "R10", "pin kept", last_rd, 32'h0177);

      // R5: halfword writes and odd sizes
      req(1, 4, 2, 32'h1234_0147, "R5");
      req(1, 6, 2, 32'h0000_F900, "R5");
      req(1, 12, 2, 32'h0000_3C08, "R5");
      req(1, 8, 2, 32'h0000_FFFF, "R5");
      req(1, 60, 2, 32'h0000_FFFF, "R5");
      req(1, 4, 3, 32'hFFFF_FFFF, "R5");
      req(1, 16, 5, 32'hFFFF_FFFF, "R5");
      req(0, 4, 4, 0, "R5");
      chk(last_rd == 32'hF900_0147, "R5", "cmd+stat", last_rd, 32'hF900_0147);

      // R7/R11: sizing write followed at once by read-back
      req(1, 16, 4, 32'hFFFF_FFFF, "R7");
      req(0, 16, 4, 0, "R11");
      chk(last_rd == 32'hFFFF_F008, "R7", "mem bar size", last_rd, 32'hFFFF_F008);
      req(1, 20, 4, 32'hFFFF_FFFF, "R7");
      req(0, 20, 4, 0, "R11");
      chk(last_rd == 32'hFFFF_FFE1, "R7", "io bar size", last_rd, 32'hFFFF_FFE1);

      // R6: plain BAR writes keep type bits
      req(1, 16, 4, 32'h1234_5677, "R6");
      req(0, 16, 4, 0, "R6");
      chk(last_rd == 32'h1234_5678, "R6", "mem bar", last_rd, 32'h1234_5678);
      req(1, 20, 4, 32'hABCD_0002, "R6");
      req(0, 20, 4, 0, "R6");
      chk(last_rd == 32'hABCD_0001, "R6", "io bar", last_rd, 32'hABCD_0001);
      req(1, 18, 4, 32'h5555_5555, "R9");

      // R8: ROM register
      req(1, 48, 4, 32'hFFFF_FFFE, "R8");
      req(0, 48, 4, 0, "R8");
      chk(last_rd == 32'hFFFF_FFFF, "R8", "rom code", last_rd, 32'hFFFF_FFFF);
      req(1, 48, 4, 32'h000C_0001, "R8");
      req(0, 48, 4, 0, "R8");
      chk(last_rd == 32'h000C_0001, "R8", "rom plain", last_rd, 32'h000C_0001);

      // R9: command via full word, other full-word targets refused
      req(1, 4, 4, 32'hAAAA_5555, "R9");
      req(0, 4, 4, 0, "R11");
      chk(last_rd == 32'hF900_5555, "R9", "cmd only", last_rd, 32'hF900_5555);
      req(1, 0, 4, 32'h0, "R9");
      req(1, 8, 4, 32'h0, "R9");
      req(1, 40, 4, 32'h0, "R9");
      req(1, 60, 4, 32'h0, "R9");
      for (int o = 0; o < 64; o += 4) req(0, o, 4, 0, "R10");

      // mixed back-to-back traffic against the model
      for (int n = 0; n < 4000; n++) begin
         int r, o, sz;
         logic [31:0] wd;
         r  = int'($urandom() & 32'hFFFF);
         o  = (r % 3 == 0) ? 16 + 4 * ((r >> 4) % 7) : (r >> 3) % 64;
         sz = (r >> 9) % 8;
         if ((r >> 12) % 2 == 1) sz = 4;
         case ((r >> 13) % 4)
            0: wd = 32'hFFFF_FFFF;
            1: wd = 32'hFFFF_FFFE;
            default: wd = $urandom();
         endcase
         req((r >> 8) % 2 == 1, o, sz, wd, "R11");
      end
      for (int o = 0; o < 64; o += 4) req(0, o, 4, 0, "R10");

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule